// File: doc/BRIEF.md
# Digital Dual-Mixer Phase Detector

This block measures the phase offset between two signals, A and B, that run at the same nominal frequency. A sampling clock runs very close to that frequency but not exactly at it. The block samples both inputs on this clock, which acts as a pair of mixers. Each sampled stream becomes a slow beat square wave, and a phase offset far smaller than one input cycle turns into a long interval between beat edges that can be counted.

Each channel passes through a synchroniser and then a run-length filter. The filter removes the chatter that slow sweeping and jitter cause around every beat edge. A free-running counter in the sampling domain tags the accepted rising edges. Each tag is taken at the first sample of the run that was accepted. The block pairs every B edge with the A edge before it. It reduces the tag difference modulo the configured beat period, folds the result to a signed value, and reports it with a one-cycle strobe.

A setpoint comparison with a dead band produces a pair of steering outputs for an external coarse phase shifter. Together they close the loop that drives the measured phase to a nominal value.

Top module: `dmtd_phase_det`

## Requirements
- R1: While rst_n is low, phase_valid, seq_err, shift_up and shift_down are all 0.
- R2: A channel's filtered level changes only after glitch_len consecutive synchronised samples at the new level. A shorter run at the new level is discarded and its samples do not count towards a later run.
- R3: The tag of a rising edge is the counter value at the first sample of the accepted run. The reported phase therefore equals (start sample of B's accepted rising run − start sample of A's accepted rising run) reduced modulo beat_period, whatever the latency of the synchroniser or the filter.
- R4: The reduced difference d lies in [0, beat_period). It is reported as d when d < beat_period/2 and as d − beat_period otherwise, so phase_out (two's complement) stays within [−beat_period/2, beat_period/2).
- R5: phase_valid is a one-cycle pulse, one cycle after an accepted B rising edge that follows an unmatched A rising edge. A B edge with no pending A edge produces no pulse, and A edges alone produce no pulse.
- R6: seq_err pulses for one cycle when an A rising edge is accepted while the previous A edge is still unmatched and no B edge is accepted in the same cycle. seq_err and phase_valid are never high together.
- R7: The tag counter is TAG_W bits wide and wraps. Results stay correct when edges fall on either side of the wrap.
- R8: One cycle after each phase_valid, shift_down becomes (phase_out − setpoint > dead_band) and shift_up becomes (phase_out − setpoint < −dead_band). Both outputs hold their values in every other cycle.
- R9: shift_up and shift_down are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp | input | 1 | Offset sampling clock; all logic runs on it |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_a | input | 1 | Reference input A, sampled as data |
| sig_b | input | 1 | Measured input B, sampled as data |
| glitch_len | input | GLEN_W | Consecutive samples needed to accept a level change |
| beat_period | input | TAG_W | Beat period in sampling-clock cycles |
| setpoint | input | TAG_W | Signed nominal phase for the steering comparison |
| dead_band | input | TAG_W | Unsigned half-width of the no-steer window |
| phase_valid | output | 1 | One-cycle strobe marking a new phase result |
| phase_out | output | TAG_W | Signed phase in sampling-clock cycles |
| seq_err | output | 1 | One-cycle pulse: two A edges without a B edge |
| shift_up | output | 1 | Measured phase is below setpoint − dead_band |
| shift_down | output | 1 | Measured phase is above setpoint + dead_band |

## Verification
The hardest case to reach is the glitch-length threshold at a beat edge. A chatter run one sample shorter than glitch_len must be discarded, and a run exactly glitch_len long must move the edge tag back to the start of that run. To reach it, the bench drives A with a fixed three-sample burst eight samples before each clean rising edge. With glitch_len 4 the measured phase equals the programmed B offset. With glitch_len 3 it moves by exactly eight. The bench sweeps every B offset across the beat period on a 10-bit tag counter, so wraps and the half-period fold point occur many times. It also stops B altogether to bring about the sequence error.

// File: rtl/dmtd_pkg.sv
package dmtd_pkg;
   localparam int NUM_CH = 2;
   typedef enum int {CH_REF = 0, CH_MEAS = 1} dmtd_ch_e;
endpackage

// File: rtl/dmtd_deglitch.sv
module dmtd_deglitch #(
   parameter int TAG_W       = 24,
   parameter int GLEN_W      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_smp,
   input  logic              rst_n,
   input  logic              din,
   input  logic [GLEN_W-1:0] glitch_len,
   input  logic [TAG_W-1:0]  tag_now,
   output logic              rise,
   output logic [TAG_W-1:0]  rise_tag
);
   logic [SYNC_STAGES-1:0] sync_sr;
   logic                   smp;
   logic                   level;
   logic [GLEN_W-1:0]      run;
   logic [TAG_W-1:0]       run_tag;
   logic                   accept;

   assign smp    = sync_sr[SYNC_STAGES-1];
   assign accept = ({1'b0, run} + 1'b1) >= {1'b0, glitch_len};

   always_ff @(posedge clk_smp) begin
      if (!rst_n) begin
         sync_sr  <= '0;
         level    <= 1'b0;
         run      <= '0;
         run_tag  <= '0;
         rise     <= 1'b0;
         rise_tag <= '0;
      end else begin
         sync_sr <= {sync_sr[SYNC_STAGES-2:0], din};
         rise    <= 1'b0;
         if (smp != level) begin
            if (run == '0) run_tag <= tag_now;
            if (accept) begin
               level <= smp;
               run   <= '0;
               if (smp) begin
                  rise     <= 1'b1;
                  rise_tag <= (run == '0) ? tag_now : run_tag;
               end
            end else begin
               run <= run + 1'b1;
            end
         end else begin
            run <= '0;
         end
      end
   end
endmodule

// File: rtl/dmtd_pair.sv
module dmtd_pair #(
   parameter int TAG_W = 24
) (
   input  logic             clk_smp,
   input  logic             rst_n,
   input  logic             edge_a,
   input  logic [TAG_W-1:0] tag_a,
   input  logic             edge_b,
   input  logic [TAG_W-1:0] tag_b,
   input  logic [TAG_W-1:0] beat_period,
   output logic             phase_valid,
   output logic [TAG_W-1:0] phase_out,
   output logic             seq_err
);
   logic             armed;
   logic [TAG_W-1:0] held_a;
   logic [TAG_W-1:0] raw, red, half, folded;

   always_comb begin
      raw    = tag_b - held_a;
      red    = (raw >= beat_period) ? raw - beat_period : raw;
      half   = beat_period >> 1;
      folded = (red >= half) ? red - beat_period : red;
   end

   always_ff @(posedge clk_smp) begin
      if (!rst_n) begin
         armed       <= 1'b0;
         held_a      <= '0;
         phase_valid <= 1'b0;
         phase_out   <= '0;
         seq_err     <= 1'b0;
      end else begin
         phase_valid <= 1'b0;
         seq_err     <= 1'b0;
         if (edge_b && armed) begin
            phase_valid <= 1'b1;
            phase_out   <= folded;
         end
         if (edge_a) begin
            armed   <= 1'b1;
            held_a  <= tag_a;
            seq_err <= armed && !edge_b;
         end else if (edge_b) begin
            armed <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dmtd_steer.sv
module dmtd_steer #(
   parameter int TAG_W = 24
) (
   input  logic             clk_smp,
   input  logic             rst_n,
   input  logic             phase_valid,
   input  logic [TAG_W-1:0] phase_out,
   input  logic [TAG_W-1:0] setpoint,
   input  logic [TAG_W-1:0] dead_band,
   output logic             shift_up,
   output logic             shift_down
);
   logic signed [TAG_W:0] err, band;

   always_comb begin
      err  = $signed({phase_out[TAG_W-1], phase_out}) - $signed({setpoint[TAG_W-1], setpoint});
      band = $signed({1'b0, dead_band});
   end

   always_ff @(posedge clk_smp) begin
      if (!rst_n) begin
         shift_up   <= 1'b0;
         shift_down <= 1'b0;
      end else if (phase_valid) begin
         shift_down <= err > band;
         shift_up   <= err < -band;
      end
   end
endmodule

// File: rtl/dmtd_phase_det.sv
module dmtd_phase_det #(
   parameter int TAG_W       = 24,
   parameter int GLEN_W      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_smp,
   input  logic              rst_n,
   input  logic              sig_a,
   input  logic              sig_b,
   input  logic [GLEN_W-1:0] glitch_len,
   input  logic [TAG_W-1:0]  beat_period,
   input  logic [TAG_W-1:0]  setpoint,
   input  logic [TAG_W-1:0]  dead_band,
   output logic              phase_valid,
   output logic [TAG_W-1:0]  phase_out,
   output logic              seq_err,
   output logic              shift_up,
   output logic              shift_down
);
   import dmtd_pkg::*;

   if (TAG_W < 4) begin : g_bad_tag_w
      $error("TAG_W must be at least 4");
   end
   if (GLEN_W < 1) begin : g_bad_glen_w
      $error("GLEN_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [TAG_W-1:0]  tag_now;
   logic [NUM_CH-1:0] ch_in, ch_rise;
   logic [TAG_W-1:0]  ch_tag [NUM_CH];

   assign ch_in[CH_REF]  = sig_a;
   assign ch_in[CH_MEAS] = sig_b;

   always_ff @(posedge clk_smp) begin
      if (!rst_n) tag_now <= '0;
      else        tag_now <= tag_now + 1'b1;
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dmtd_deglitch #(.TAG_W(TAG_W), .GLEN_W(GLEN_W), .SYNC_STAGES(SYNC_STAGES)) u_dg (
         .clk_smp    (clk_smp),
         .rst_n      (rst_n),
         .din        (ch_in[c]),
         .glitch_len (glitch_len),
         .tag_now    (tag_now),
         .rise       (ch_rise[c]),
         .rise_tag   (ch_tag[c])
      );
   end

   dmtd_pair #(.TAG_W(TAG_W)) u_pair (
      .clk_smp     (clk_smp),
      .rst_n       (rst_n),
      .edge_a      (ch_rise[CH_REF]),
      .tag_a       (ch_tag[CH_REF]),
      .edge_b      (ch_rise[CH_MEAS]),
      .tag_b       (ch_tag[CH_MEAS]),
      .beat_period (beat_period),
      .phase_valid (phase_valid),
      .phase_out   (phase_out),
      .seq_err     (seq_err)
   );

   dmtd_steer #(.TAG_W(TAG_W)) u_steer (
      .clk_smp     (clk_smp),
      .rst_n       (rst_n),
      .phase_valid (phase_valid),
      .phase_out   (phase_out),
      .setpoint    (setpoint),
      .dead_band   (dead_band),
      .shift_up    (shift_up),
      .shift_down  (shift_down)
   );
endmodule

// File: rtl/dmtd_phase_det_chk.sv
module dmtd_phase_det_chk #(
   parameter int TAG_W = 24
) (
   input logic             clk_smp,
   input logic             rst_n,
   input logic [TAG_W-1:0] beat_period,
   input logic             phase_valid,
   input logic [TAG_W-1:0] phase_out,
   input logic             seq_err,
   input logic             shift_up,
   input logic             shift_down
);
   logic signed [TAG_W+1:0] ph_x, half_x;
   assign ph_x   = $signed({{2{phase_out[TAG_W-1]}}, phase_out});
   assign half_x = $signed({2'b00, beat_period >> 1});

   a_r1_reset_quiet: assert property (@(posedge clk_smp)
      !rst_n |=> !phase_valid && !seq_err && !shift_up && !shift_down);

   a_r4_phase_range: assert property (@(posedge clk_smp) disable iff (!rst_n)
      phase_valid |-> (ph_x >= -half_x) && (ph_x < half_x));

   a_r5_valid_pulse: assert property (@(posedge clk_smp) disable iff (!rst_n)
      phase_valid |=> !phase_valid);

   a_r6_err_excl: assert property (@(posedge clk_smp) disable iff (!rst_n)
      !(seq_err && phase_valid));

   a_r8_steer_hold: assert property (@(posedge clk_smp) disable iff (!rst_n)
      !phase_valid |=> $stable(shift_up) && $stable(shift_down));

   a_r9_steer_excl: assert property (@(posedge clk_smp) disable iff (!rst_n)
      !(shift_up && shift_down));
endmodule

bind dmtd_phase_det dmtd_phase_det_chk #(.TAG_W(TAG_W)) u_chk (
   .clk_smp     (clk_smp),
   .rst_n       (rst_n),
   .beat_period (beat_period),
   .phase_valid (phase_valid),
   .phase_out   (phase_out),
   .seq_err     (seq_err),
   .shift_up    (shift_up),
   .shift_down  (shift_down)
);

// File: tb/dmtd_phase_det_bench.sv
module dmtd_phase_det_bench;
   localparam int TW = 10;
   localparam int GW = 5;
   localparam int P  = 64;
   localparam int SP = 5;
   localparam int DB = 3;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          sig_a = 1'b0;
   logic          sig_b = 1'b0;
   logic [GW-1:0] glen;
   logic [TW-1:0] period, band, setp;
   logic          phase_valid, seq_err, shift_up, shift_down;
   logic [TW-1:0] phase_out;

   dmtd_phase_det #(.TAG_W(TW), .GLEN_W(GW), .SYNC_STAGES(2)) u_dmtd_phase_det (
      .clk_smp(clk), .rst_n(rst_n), .sig_a(sig_a), .sig_b(sig_b),
      .glitch_len(glen), .beat_period(period), .setpoint(setp), .dead_band(band),
      .phase_valid(phase_valid), .phase_out(phase_out), .seq_err(seq_err),
      .shift_up(shift_up), .shift_down(shift_down)
   );

   int total = 0;
   int bad   = 0;
   int k     = 0;
   int d     = 0;
   bit b_en  = 1'b1;
   int n_both_vs = 0;
   int n_both_sh = 0;

   function automatic bit gen_a(int kk);
      int m = kk % P;
      return (m < P/2) || m == P-8 || m == P-7 || m == P-6 || m == P-3 || m == P/2+1;
   endfunction

   function automatic bit gen_b(int kk, int dd);
      int m = (kk - dd + P*100000) % P;
      return (m < P/2) || m == P-2;
   endfunction

   function automatic int fold(int x);
      int m = ((x % P) + P) % P;
      return (m >= P/2) ? m - P : m;
   endfunction

   always @(negedge clk) begin
      k     <= k + 1;
      sig_a <= gen_a(k);
      sig_b <= b_en ? gen_b(k, d) : 1'b0;
   end

   always @(negedge clk) begin
      if (rst_n && seq_err && phase_valid) n_both_vs++;
      if (rst_n && shift_up && shift_down) n_both_sh++;
   end

   task automatic chk(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_valid(output int ph, output bit got);
      got = 1'b0;
      ph  = 0;
      for (int i = 0; i < 4*P; i++) begin
         @(negedge clk);
         if (phase_valid) begin
            ph  = $signed(phase_out);
            got = 1'b1;
            return;
         end
      end
   endtask

   task automatic check_offset(int dd, int lenv, int a_lead);
      int ph, exp_ph, e;
      bit got;
      d    = dd;
      glen = GW'(lenv);
      wait_valid(ph, got);
      wait_valid(ph, got);
      wait_valid(ph, got);
      exp_ph = fold(dd + a_lead);
      chk(got, "R5 valid strobe present", int'(got), 1);
      chk(ph == exp_ph, "R2 R3 R4 R7 phase value", ph, exp_ph);
      @(negedge clk);
      e = ph - SP;
      chk(shift_down == (e > DB), "R8 shift_down", int'(shift_down), int'(e > DB));
      chk(shift_up == (e < -DB), "R8 shift_up", int'(shift_up), int'(e < -DB));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n_err, n_val;
      glen   = GW'(4);
      period = TW'(P);
      setp   = TW'(SP);
      band   = TW'(DB);
      repeat (5) @(negedge clk);
      // R1: reset state
      chk(!phase_valid && !seq_err, "R1 reset valid/err", int'(phase_valid | seq_err), 0);
      chk(!shift_up && !shift_down, "R1 reset steer", int'(shift_up | shift_down), 0);
      rst_n = 1'b1;

      // Full sweep, 3-sample chatter on A rejected (R2), tag counter wraps (R7)
      for (int dd = 0; dd < P; dd++) check_offset(dd, 4, 0);

      // R2 threshold: a run of exactly glitch_len moves A's edge 8 samples earlier
      check_offset(0, 3, 8);
      check_offset(5, 3, 8);
      check_offset(24, 3, 8);
      check_offset(40, 3, 8);
      check_offset(60, 3, 8);

      // R5 R6: B stopped, A edges alone
      d    = 10;
      glen = GW'(4);
      b_en = 1'b0;
      repeat (20) @(negedge clk);
      n_err = 0;
      n_val = 0;
      for (int i = 0; i < 3*P; i++) begin
         @(negedge clk);
         if (seq_err) n_err++;
         if (phase_valid) n_val++;
      end
      chk(n_err >= 1, "R6 seq_err on A without B", n_err, 2);
      chk(n_val == 0, "R5 no valid without B", n_val, 0);
      b_en = 1'b1;

      check_offset(10, 4, 0);
      check_offset(P/2, 4, 0);

      chk(n_both_vs == 0, "R6 err/valid exclusive", n_both_vs, 0);
      chk(n_both_sh == 0, "R9 steer exclusive", n_both_sh, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule